// File: doc/BRIEF.md
# Parallel Host Bus Register Interface

This block is the processor-facing slave of a data converter's parallel bus. A host selects the block with a pair of chip selects of opposite polarity. It then either writes one of four control registers or reads the sample at the head of the converter's output FIFO. The write pin has two roles that change at run time. In combined mode it is a read/write direction line. In split mode it is an active-low write strobe, and a separate active-low read strobe is used for reads.

During a write, the two most significant bus bits carry the register address and the remaining ten bits carry the payload. The strobe mode bit lives in register 0. Its reset value selects combined mode, so after power-up the host's first access should be a write that configures the interface. Reads drive the FIFO head onto the bus through an output enable. They issue one FIFO advance pulse after each read access ends, so the data stays stable for the whole access. All pins are sampled in the `clk` domain and are assumed to be synchronized already.

Top module: `hostbus_regif`

## Requirements
- R1: The block counts as selected only while `cs_lo_n` is 0 and `cs_hi` is 1. While it is not selected, no register changes and no `head_pop` pulse is produced.
- R2: `bus_oe` is 0 whenever the block is not selected, and also whenever `wr_rw` is 0.
- R3: In combined mode (register 0 bit 0 = 0), a selected access with `wr_rw` = 0 is a write and one with `wr_rw` = 1 is a read. In this mode `rd_n` has no effect.
- R4: In split mode (register 0 bit 0 = 1), a selected access with `wr_rw` = 0 is a write. A read needs `rd_n` = 0 with `wr_rw` = 1; `wr_rw` = 1 alone is no access.
- R5: A write takes effect on the first clock after the write access ends, whether it ends by `wr_rw` rising or by the block being deselected. Bits 11:10 of the bus word from the last cycle of the access select the register, and bits 9:0 are stored in it. The other registers keep their values.
- R6: Reset loads every register from `RST_VAL` (register i in bits 10*i+9 down to 10*i). Register 0 bit 0 resets to 0, which is combined mode.
- R7: Throughout a read access, `bus_oe` is 1 and `bus_out` equals `head_data`.
- R8: Each read access, whatever its length, produces exactly one `head_pop` pulse of one cycle, in the second clock after the access ends.
- R9: A write to the register 0 mode bit changes how the next access is decoded.
- R10: `ctrl_regs` presents register i in bits 10*i+9 down to 10*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low hardware reset |
| cs_lo_n | input | 1 | Active-low chip select |
| cs_hi | input | 1 | Active-high chip select |
| wr_rw | input | 1 | Read/write direction (combined mode) or active-low write strobe (split mode) |
| rd_n | input | 1 | Active-low read strobe, used in split mode only |
| bus_in | input | 12 | Bus value seen from the pins |
| bus_out | output | 12 | Value driven onto the bus during reads |
| bus_oe | output | 1 | Bus driver enable |
| head_data | input | 12 | Current FIFO head sample |
| head_pop | output | 1 | One-cycle FIFO advance pulse |
| ctrl_regs | output | 40 | All four control registers, flattened |

## Verification
A wrong address or payload capture shows on `ctrl_regs` one clock after the write access ends. The bench therefore compares all four registers after every write, so that writes to the wrong register are caught. A wrong mode bit changes which pin combinations enable `bus_oe`, and that shows in the same cycle as the strobe. A wrong read-edge tracker shows as a missing or extra `head_pop`. It is seen two clocks after the access ends, and the bench counts pulses over reads of several lengths.

// File: rtl/hostbus_regif.sv
module hostbus_regif #(
  parameter int DW = 12,
  parameter int AW = 2,
  parameter int MODE_BIT = 0,
  parameter logic [(1<<AW)*(DW-AW)-1:0] RST_VAL = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_lo_n,
  input  logic                          cs_hi,
  input  logic                          wr_rw,
  input  logic                          rd_n,
  input  logic [DW-1:0]                 bus_in,
  output logic [DW-1:0]                 bus_out,
  output logic                          bus_oe,
  input  logic [DW-1:0]                 head_data,
  output logic                          head_pop,
  output logic [(1<<AW)*(DW-AW)-1:0]    ctrl_regs
);
  localparam int PW   = DW - AW;
  localparam int NREG = 1 << AW;

  logic          sel, split, wr_act, rd_act, commit;
  logic          wr_q, rd_q, pop_q;
  logic [DW-1:0] dat_q;
  logic [PW-1:0] regs [NREG];

  assign sel    = ~cs_lo_n & cs_hi;
  assign split  = regs[0][MODE_BIT];
  assign wr_act = sel & ~wr_rw;
  assign rd_act = sel & wr_rw & (split ? ~rd_n : 1'b1);
  assign commit = wr_q & ~wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      pop_q <= 1'b0;
      dat_q <= '0;
    end else begin
      wr_q  <= wr_act;
      rd_q  <= rd_act;
      pop_q <= rd_q & ~rd_act;
      if (wr_act) dat_q <= bus_in;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= RST_VAL[i*PW +: PW];
      else if (commit && dat_q[DW-1 -: AW] == AW'(i))
        regs[i] <= dat_q[PW-1:0];
    end
    assign ctrl_regs[i*PW +: PW] = regs[i];
  end

  assign bus_oe   = rd_act;
  assign bus_out  = rd_act ? head_data : '0;
  assign head_pop = pop_q;
endmodule

module hostbus_regif_chk #(
  parameter int RW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_lo_n,
  input logic          cs_hi,
  input logic          wr_rw,
  input logic          bus_oe,
  input logic          head_pop,
  input logic [RW-1:0] ctrl_regs
);
  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lo_n || !cs_hi) |-> !bus_oe); // R2
  AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rw |-> !bus_oe); // R2
  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    head_pop |=> !head_pop); // R8
  AST_POP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    head_pop |-> ($past(bus_oe, 2) && !$past(bus_oe))); // R8
  AST_REG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_regs) |-> $past(!cs_lo_n && cs_hi && !wr_rw, 2)); // R5
endmodule

bind hostbus_regif hostbus_regif_chk #(.RW(NREG*PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi), .wr_rw(wr_rw),
  .bus_oe(bus_oe), .head_pop(head_pop), .ctrl_regs(ctrl_regs)
);

// File: tb/hostbus_regif_tb.sv
module hostbus_regif_tb;
  localparam logic [39:0] RV = {10'h2A5, 10'h0F0, 10'h3C1, 10'h000};
  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{12'h4A5, 12'h8FF, 12'hC3A, 12'h2FE,
                                       12'h7FF, 12'h800, 12'hD55, 12'h000};

  logic clk = 0, rst_n = 0;
  logic cs_lo_n = 1, cs_hi = 0, wr_rw = 1, rd_n = 1;
  logic [11:0] bus_in = '0, head_data = '0;
  logic [11:0] bus_out;
  logic bus_oe, head_pop;
  logic [39:0] ctrl_regs;
  logic [39:0] model;
  int total = 0, bad = 0, pops = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (head_pop) pops <= pops + 1;

  hostbus_regif #(.RST_VAL(RV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi), .wr_rw(wr_rw),
    .rd_n(rd_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .head_data(head_data), .head_pop(head_pop), .ctrl_regs(ctrl_regs)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_lo_n = 1; cs_hi = 0; wr_rw = 1; rd_n = 1;
  endtask

  task automatic wr(input logic [11:0] d, input logic lo_n, input logic hi);
    @(negedge clk); cs_lo_n = lo_n; cs_hi = hi; wr_rw = 0; bus_in = d;
    @(negedge clk); chk("R2 oe during write", {39'd0, bus_oe}, 40'd0);
    idle();
    @(negedge clk);
  endtask

  task automatic rd(input int n, input logic use_rd, input logic expect_rd, input string req);
    int p0;
    p0 = pops;
    @(negedge clk); cs_lo_n = 0; cs_hi = 1; wr_rw = 1; rd_n = ~use_rd;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk({req, " oe"}, {39'd0, bus_oe}, {39'd0, expect_rd});
      chk({req, " data"}, {28'd0, bus_out}, expect_rd ? {28'd0, head_data} : 40'd0);
    end
    idle();
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk({req, " pop count"}, 40'(pops - p0), expect_rd ? 40'd1 : 40'd0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset regs", ctrl_regs, RV);
    chk("R2 oe in reset idle", {39'd0, bus_oe}, 40'd0);
    rst_n = 1;
    model = RV;

    // R5 R10 vector walk in combined mode
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i], 0, 1);
      model[VEC[i][11:10]*10 +: 10] = VEC[i][9:0];
      chk("R5 R10 table write", ctrl_regs, model);
    end

    // R1 deselected writes ignored
    wr(12'h5AA, 1, 1);
    chk("R1 cs_lo_n high blocks write", ctrl_regs, model);
    wr(12'h5AA, 0, 0);
    chk("R1 cs_hi low blocks write", ctrl_regs, model);

    // R3 combined-mode reads; rd_n ignored
    head_data = 12'hA5C;
    rd(1, 0, 1, "R3 R7 R8 short read");
    head_data = 12'h3E1;
    rd(4, 1, 1, "R3 R8 long read rd_n low");
    @(negedge clk); cs_lo_n = 1; cs_hi = 1; wr_rw = 1;
    @(negedge clk); chk("R1 oe deselected", {39'd0, bus_oe}, 40'd0);
    idle();

    // R9 switch to split mode
    wr(12'h001, 0, 1);
    model[9:0] = 10'h001;
    chk("R9 mode bit written", ctrl_regs, model);
    head_data = 12'h777;
    rd(2, 0, 0, "R4 wr_rw high alone no read");
    rd(3, 1, 1, "R4 R7 R8 split read");
    wr(12'hB33, 0, 1);
    model[29:20] = 10'h333;
    chk("R4 split write", ctrl_regs, model);

    // R5 write ending by rising wr_rw while still selected (split mode, rd_n high)
    @(negedge clk); cs_lo_n = 0; cs_hi = 1; wr_rw = 0; bus_in = 12'h4C4;
    @(negedge clk); bus_in = 12'h4C7;
    @(negedge clk); wr_rw = 1;
    @(negedge clk);
    model[19:10] = 10'h0C7;
    chk("R5 last-cycle data, end by strobe", ctrl_regs, model);
    chk("R4 no read after strobe end", {39'd0, bus_oe}, 40'd0);
    idle();

    // R9 back to combined
    wr(12'h000, 0, 1);
    model[9:0] = 10'h000;
    rd(1, 0, 1, "R9 combined again");

    // R6 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); chk("R6 reset restores", ctrl_regs, RV);
    rst_n = 1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule